// File: doc/BRIEF.md
# Edge interrupt pending-flag controller

This block holds the pending-interrupt state for four external interrupt lines that sit sparsely in a 32-bit register word. Each line goes through a two-flop synchronizer and then an edge detector. Software picks which edges count on each line: rising, falling, both or neither. When a selected edge arrives, it sets a sticky pending flag for that line. Software clears a flag by writing 1 to its bit.

Each line also has a mask bit and a software-trigger bit. Writing 1 to a software-trigger bit sets that line's pending flag, but only while the line is unmasked. The trigger bit then stays at 1 until the pending flag is cleared. The single interrupt request output is registered. It is high when any line has both its pending flag and its mask bit set. A plain register bus reads and writes five registers. Reads are combinational and writes take effect on the clock edge.

Top module: `edge_pend_ctrl`

## Requirements
- R1: After reset, the mask, rising-select, falling-select, pending and software-trigger registers all read 0, and `irq_o` is 0.
- R2: Lines 0 and 1 of `line_in` use bits 0 and 1 of every register. Lines 2 and 3 use bits 8 and 9. All other bits read as 0 and ignore writes, in every register. The register offsets are: mask 0x28, rising-select 0x2C, falling-select 0x30, pending 0x34, software-trigger 0x38.
- R3: A 0-to-1 change on a line whose rising-select bit is 1 sets that line's pending flag. The flag is set on the third rising clock edge after the input changes.
- R4: A 1-to-0 change on a line whose falling-select bit is 1 sets that line's pending flag, with the same latency as R3.
- R5: An edge whose select bit is 0 leaves the pending flag unchanged.
- R6: A write to the pending register clears each flag written with 1. Flags written with 0 keep their value.
- R7: If a selected edge and a write of 1 to the same pending bit happen in the same cycle, the edge wins and the flag reads 1 afterwards.
- R8: Writing 1 to a software-trigger bit that reads 0, while the line's mask bit is 1, sets both that trigger bit and the line's pending flag.
- R9: Writing 1 to a software-trigger bit on a masked line has no effect on that trigger bit or on the pending flag.
- R10: Clearing a pending flag by a write of 1 also clears that line's software-trigger bit.
- R11: `irq_o` is the OR, over the four lines, of pending AND mask, delayed by one register. A pending flag on a masked line does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 4 | Asynchronous external interrupt lines |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Four behaviours are checked on every cycle by properties:
- A pending flag never drops unless the pending register was written.
- A software-trigger bit is never set without a matching pending flag.
- A software-trigger bit becomes 1 only on a line that was unmasked.
- `irq_o` rises only after some pending-and-unmasked line existed.

Other behaviours need the bench's directed scenarios, because they depend on a specific sequence of stimulus:
- the three-cycle edge latency for each polarity;
- the edge winning over a clear in the same cycle;
- the reserved bits staying at zero.

// File: rtl/edge_pend_ctrl.sv
module edge_pend_ctrl #(
  parameter int ADDR_W = 8,
  parameter int NLINE = 4,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h28,
  parameter logic [ADDR_W-1:0] OFS_RISE = 8'h2C,
  parameter logic [ADDR_W-1:0] OFS_FALL = 8'h30,
  parameter logic [ADDR_W-1:0] OFS_PEND = 8'h34,
  parameter logic [ADDR_W-1:0] OFS_SWT  = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINE-1:0]  line_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  function automatic logic [NLINE-1:0] pick(input logic [31:0] w);
    return {w[9], w[8], w[1], w[0]};
  endfunction

  function automatic logic [31:0] spread(input logic [NLINE-1:0] v);
    return {22'b0, v[3:2], 6'b0, v[1:0]};
  endfunction

  logic [NLINE-1:0] sync1, sync2, prev;
  logic [NLINE-1:0] mask, rise, fall, pend, swt;
  logic             irq_q;

  wire [NLINE-1:0] wbits  = pick(bus_wdata);
  wire [NLINE-1:0] edg    = (sync2 & ~prev & rise) | (~sync2 & prev & fall);
  wire [NLINE-1:0] clr    = (bus_wen && bus_addr == OFS_PEND) ? wbits : '0;
  wire [NLINE-1:0] sw_set = (bus_wen && bus_addr == OFS_SWT) ? (wbits & ~swt & mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      mask  <= '0;
      rise  <= '0;
      fall  <= '0;
      pend  <= '0;
      swt   <= '0;
      irq_q <= 1'b0;
    end else begin
      sync1 <= line_in;
      sync2 <= sync1;
      prev  <= sync2;
      if (bus_wen && bus_addr == OFS_MASK) mask <= wbits;
      if (bus_wen && bus_addr == OFS_RISE) rise <= wbits;
      if (bus_wen && bus_addr == OFS_FALL) fall <= wbits;
      pend  <= (pend & ~clr) | edg | sw_set;
      swt   <= (swt | sw_set) & ~clr;
      irq_q <= |(pend & mask);
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MASK: bus_rdata = spread(mask);
      OFS_RISE: bus_rdata = spread(rise);
      OFS_FALL: bus_rdata = spread(fall);
      OFS_PEND: bus_rdata = spread(pend);
      OFS_SWT:  bus_rdata = spread(swt);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o = irq_q;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !(bus_wen && bus_addr == OFS_PEND)) |=> ((pend & $past(pend)) == $past(pend)));

  p_swt_in_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (swt & ~pend) == '0);

  p_swt_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((swt & ~$past(swt) & ~$past(mask)) == '0));

  p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(irq_q)) |-> $past((pend & mask) != '0));

endmodule

// File: tb/edge_pend_ctrl_tb_top.sv
module edge_pend_ctrl_tb_top;
  localparam logic [7:0] A_MASK = 8'h28, A_RISE = 8'h2C, A_FALL = 8'h30,
                         A_PEND = 8'h34, A_SWT = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  line_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  always #10 clk = ~clk;

  edge_pend_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  bit chk_req = 1'b0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(negedge clk) begin
    if (chk_req && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    tick();
    bus_wen = 1'b0;
  endtask

  task automatic chk(bit is_irq, logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    it.is_irq = is_irq; it.exp = e; it.tag = tag;
    q.push_back(it);
    bus_addr = a; chk_req = 1'b1;
    @(negedge clk); #1;
    chk_req = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    chk(0, A_MASK, 32'h0, "R1 mask");
    chk(0, A_RISE, 32'h0, "R1 rise");
    chk(0, A_FALL, 32'h0, "R1 fall");
    chk(0, A_PEND, 32'h0, "R1 pend");
    chk(0, A_SWT,  32'h0, "R1 swt");
    chk(1, 8'h0,   32'h0, "R1 irq");

    wr(A_MASK, 32'hFFFF_FFFF);
    chk(0, A_MASK, 32'h303, "R2 mask reserved");
    wr(A_MASK, 32'h0);

    wr(A_RISE, 32'h1);
    line_in[0] = 1'b1;
    tick(2);
    chk(0, A_PEND, 32'h0, "R3 not yet at 2 edges");
    tick(1);
    chk(0, A_PEND, 32'h1, "R3 rise line0");
    tick(2);
    chk(1, 8'h0, 32'h0, "R11 masked no irq");
    wr(A_MASK, 32'h1);
    tick(1);
    chk(1, 8'h0, 32'h1, "R11 irq unmasked");

    wr(A_PEND, 32'h0);
    chk(0, A_PEND, 32'h1, "R6 write 0 keeps");
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h0, "R6 w1c");
    tick(1);
    chk(1, 8'h0, 32'h0, "R11 irq drop");

    wr(A_FALL, 32'h200);
    line_in[3] = 1'b1;
    tick(4);
    chk(0, A_PEND, 32'h0, "R5 unselected rise");
    line_in[3] = 1'b0;
    tick(4);
    chk(0, A_PEND, 32'h200, "R4 fall line3");
    wr(A_PEND, 32'h200);

    line_in[2] = 1'b1; tick(4);
    line_in[2] = 1'b0; tick(4);
    chk(0, A_PEND, 32'h0, "R5 line2 no select");

    wr(A_FALL, 32'h201);
    line_in[0] = 1'b0;
    tick(2);
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h1, "R7 edge beats clear");
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h0, "R7 later clear");

    wr(A_SWT, 32'h100);
    chk(0, A_SWT,  32'h0, "R9 masked swt");
    chk(0, A_PEND, 32'h0, "R9 masked pend");
    wr(A_SWT, 32'h1);
    chk(0, A_SWT,  32'h1, "R8 swt set");
    chk(0, A_PEND, 32'h1, "R8 pend set");
    tick(1);
    chk(1, 8'h0, 32'h1, "R8 irq");
    wr(A_SWT, 32'h1);
    chk(0, A_SWT, 32'h1, "R9 swt already set");
    wr(A_PEND, 32'h1);
    chk(0, A_SWT,  32'h0, "R10 swt cleared");
    chk(0, A_PEND, 32'h0, "R10 pend cleared");
    wr(A_SWT, 32'h4);
    chk(0, A_SWT, 32'h0, "R2 swt reserved");

    tick(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule